// File: doc/BRIEF.md
# Dual-File Operand Register Select

This block sits between instruction decode and the execution pipes. It keeps two register files, one for integer values and one for floating-point values. Each file has 32 entries of 64 bits, three read ports and one write port. For each instruction, decode supplies three source register numbers, a two-bit access code and a pipe-select flag. The access code chooses which file supplies all three operands.

One clock edge later the block presents the operand triple, together with the decoded packet that came with the request, on one of two output groups. One group feeds the integer and memory-address pipe and the other feeds the floating-point pipe. The pipe-select flag chooses the group. A separate write port, driven by write-back, updates one entry in the file that the write-target flag names. A read and a write to the same register in the same cycle return the value being written.

Top module: `opnd_regsel`

## Requirements
- R1: While `rst_n` is low, both output valids are low and every operand and packet output is zero.
- R2: A request sampled at one rising edge of `clk` shows up on the outputs right after that edge. The valid is high for exactly that one cycle unless another request follows.
- R3: Access code 2'b01 reads all three operands from the integer file. Access code 2'b10 reads all three from the floating-point file.
- R4: Access codes 2'b00 and 2'b11 are no-access. A request that carries one of them raises neither output valid, and all operand outputs read zero.
- R5: An accepted request with `pipe_fp` = 0 appears on the `ix_*` outputs. With `pipe_fp` = 1 it appears on the `fp_*` outputs. An output group whose valid is low shows zero on its operands and packet.
- R6: The packet shown with a set of operands is the `pkt_in` value that was sampled with the request.
- R7: Integer register 0 always reads as zero. A write to it has no effect, even when a read of it happens in the same cycle.
- R8: Floating-point register 0 is an ordinary register. It returns the last value written to it.
- R9: A write with `wr_fp` = 1 updates only the floating-point file. A write with `wr_fp` = 0 updates only the integer file.
- R10: A read in the same cycle as a write to the same register of the same file returns the new write data. A write to the same number in the other file does not change what the read returns.
- R11: The three read ports are independent. Any mix of addresses, including all three equal and the top register 31, returns each addressed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| in_valid | input | 1 | Operand request present this cycle |
| acc_code | input | 2 | 01 integer file, 10 floating-point file, 00/11 no access |
| pipe_fp | input | 1 | 0 steers to the integer/memory pipe, 1 to the floating-point pipe |
| src_a | input | 5 | First source register number |
| src_b | input | 5 | Second source register number |
| src_c | input | 5 | Third source register number |
| pkt_in | input | 16 | Decoded instruction packet travelling with the request |
| wr_en | input | 1 | Write-back enable |
| wr_fp | input | 1 | Write target: 1 floating-point file, 0 integer file |
| wr_addr | input | 5 | Register number written |
| wr_data | input | 64 | Write-back data |
| ix_valid | output | 1 | Operands valid for the integer/memory pipe |
| ix_op_a | output | 64 | Integer pipe operand A |
| ix_op_b | output | 64 | Integer pipe operand B |
| ix_op_c | output | 64 | Integer pipe operand C |
| ix_pkt | output | 16 | Packet for the integer pipe |
| fp_valid | output | 1 | Operands valid for the floating-point pipe |
| fp_op_a | output | 64 | Floating-point pipe operand A |
| fp_op_b | output | 64 | Floating-point pipe operand B |
| fp_op_c | output | 64 | Floating-point pipe operand C |
| fp_pkt | output | 16 | Packet for the floating-point pipe |

## Verification
The bench builds the block with its default values: 32 registers of 64 bits and a 16-bit packet. With these values register 0 and register 31, the two ends of the address space, can be hit directly. Random source and write addresses drawn over the full 5-bit range make same-cycle read/write collisions happen often, about once in 32 draws per port. Full 64-bit random data makes any dropped or crossed bit between the two files visible.

// File: rtl/opnd_regsel.sv
module opnd_regsel #(
  parameter int NREG = 32,
  parameter int DW   = 64,
  parameter int PKTW = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      acc_code,
  input  logic            pipe_fp,
  input  logic [AW-1:0]   src_a,
  input  logic [AW-1:0]   src_b,
  input  logic [AW-1:0]   src_c,
  input  logic [PKTW-1:0] pkt_in,
  input  logic            wr_en,
  input  logic            wr_fp,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic            ix_valid,
  output logic [DW-1:0]   ix_op_a,
  output logic [DW-1:0]   ix_op_b,
  output logic [DW-1:0]   ix_op_c,
  output logic [PKTW-1:0] ix_pkt,
  output logic            fp_valid,
  output logic [DW-1:0]   fp_op_a,
  output logic [DW-1:0]   fp_op_b,
  output logic [DW-1:0]   fp_op_c,
  output logic [PKTW-1:0] fp_pkt
);

  localparam logic [1:0] ACC_INT = 2'b01;
  localparam logic [1:0] ACC_FP  = 2'b10;

  logic [DW-1:0] irf [NREG];
  logic [DW-1:0] frf [NREG];

  logic [AW-1:0] src  [3];
  logic [DW-1:0] opnd [3];

  assign src[0] = src_a;
  assign src[1] = src_b;
  assign src[2] = src_c;

  wire use_int = (acc_code == ACC_INT);
  wire use_fp  = (acc_code == ACC_FP);
  wire req     = in_valid && (use_int || use_fp);
  wire to_ix   = req && !pipe_fp;
  wire to_fp   = req && pipe_fp;
  wire wr_int  = wr_en && !wr_fp && (wr_addr != '0);
  wire wr_flt  = wr_en && wr_fp;

  always_ff @(posedge clk) begin
    if (wr_int) irf[wr_addr] <= wr_data;
    if (wr_flt) frf[wr_addr] <= wr_data;
  end

  always_comb begin
    for (int p = 0; p < 3; p++) begin
      opnd[p] = '0;
      if (use_int) begin
        if (src[p] == '0)                      opnd[p] = '0;
        else if (wr_int && wr_addr == src[p])  opnd[p] = wr_data;
        else                                   opnd[p] = irf[src[p]];
      end else if (use_fp) begin
        if (wr_flt && wr_addr == src[p])       opnd[p] = wr_data;
        else                                   opnd[p] = frf[src[p]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ix_valid <= 1'b0;
      ix_op_a  <= '0;
      ix_op_b  <= '0;
      ix_op_c  <= '0;
      ix_pkt   <= '0;
      fp_valid <= 1'b0;
      fp_op_a  <= '0;
      fp_op_b  <= '0;
      fp_op_c  <= '0;
      fp_pkt   <= '0;
    end else begin
      ix_valid <= to_ix;
      ix_op_a  <= to_ix ? opnd[0] : '0;
      ix_op_b  <= to_ix ? opnd[1] : '0;
      ix_op_c  <= to_ix ? opnd[2] : '0;
      ix_pkt   <= to_ix ? pkt_in  : '0;
      fp_valid <= to_fp;
      fp_op_a  <= to_fp ? opnd[0] : '0;
      fp_op_b  <= to_fp ? opnd[1] : '0;
      fp_op_c  <= to_fp ? opnd[2] : '0;
      fp_pkt   <= to_fp ? pkt_in  : '0;
    end
  end

endmodule

// File: rtl/opnd_regsel_chk.sv
module opnd_regsel_chk #(
  parameter int DW   = 64,
  parameter int PKTW = 16,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      acc_code,
  input logic            pipe_fp,
  input logic [AW-1:0]   src_a,
  input logic [PKTW-1:0] pkt_in,
  input logic            wr_en,
  input logic            wr_fp,
  input logic [AW-1:0]   wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic            ix_valid,
  input logic [DW-1:0]   ix_op_a,
  input logic [DW-1:0]   ix_op_b,
  input logic [DW-1:0]   ix_op_c,
  input logic [PKTW-1:0] ix_pkt,
  input logic            fp_valid,
  input logic [DW-1:0]   fp_op_a,
  input logic [DW-1:0]   fp_op_b,
  input logic [DW-1:0]   fp_op_c,
  input logic [PKTW-1:0] fp_pkt
);

  wire acc_ok = (acc_code == 2'b01) || (acc_code == 2'b10);

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!ix_valid && !fp_valid);
    end
  end

  p_one_pipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ix_valid && fp_valid));

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ix_valid |-> (ix_op_a == '0 && ix_op_b == '0 && ix_op_c == '0 && ix_pkt == '0));

  p_latency_ix_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_ok && !pipe_fp) |=> (ix_valid && !fp_valid));

  p_latency_fp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_ok && pipe_fp) |=> (fp_valid && !ix_valid));

  p_no_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_ok) |=> (!ix_valid && !fp_valid && ix_op_a == '0 && fp_op_a == '0));

  p_pkt_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_ok && !pipe_fp) |=> (ix_pkt == $past(pkt_in)));

  p_int_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_code == 2'b01 && !pipe_fp && src_a == '0) |=> (ix_op_a == '0));

  p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_code == 2'b10 && pipe_fp && wr_en && wr_fp && wr_addr == src_a)
      |=> (fp_op_a == $past(wr_data)));

endmodule

bind opnd_regsel opnd_regsel_chk #(.DW(DW), .PKTW(PKTW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_code(acc_code),
  .pipe_fp(pipe_fp), .src_a(src_a), .pkt_in(pkt_in), .wr_en(wr_en),
  .wr_fp(wr_fp), .wr_addr(wr_addr), .wr_data(wr_data),
  .ix_valid(ix_valid), .ix_op_a(ix_op_a), .ix_op_b(ix_op_b), .ix_op_c(ix_op_c),
  .ix_pkt(ix_pkt), .fp_valid(fp_valid), .fp_op_a(fp_op_a), .fp_op_b(fp_op_b),
  .fp_op_c(fp_op_c), .fp_pkt(fp_pkt)
);

// File: tb/opnd_regsel_tb_top.sv
`timescale 1ns/1ps
module opnd_regsel_tb_top;
  localparam int NREG = 32;
  localparam int DW   = 64;
  localparam int PKTW = 16;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] acc_code = 2'b00;
  logic pipe_fp = 1'b0;
  logic [AW-1:0] src_a = '0, src_b = '0, src_c = '0;
  logic [PKTW-1:0] pkt_in = '0;
  logic wr_en = 1'b0, wr_fp = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic ix_valid, fp_valid;
  logic [DW-1:0] ix_op_a, ix_op_b, ix_op_c, fp_op_a, fp_op_b, fp_op_c;
  logic [PKTW-1:0] ix_pkt, fp_pkt;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  logic [DW-1:0] m_int [NREG];
  logic [DW-1:0] m_fp  [NREG];

  always #2.5 clk = ~clk;

  opnd_regsel #(.NREG(NREG), .DW(DW), .PKTW(PKTW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_code(acc_code),
    .pipe_fp(pipe_fp), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .pkt_in(pkt_in), .wr_en(wr_en), .wr_fp(wr_fp), .wr_addr(wr_addr),
    .wr_data(wr_data), .ix_valid(ix_valid), .ix_op_a(ix_op_a),
    .ix_op_b(ix_op_b), .ix_op_c(ix_op_c), .ix_pkt(ix_pkt),
    .fp_valid(fp_valid), .fp_op_a(fp_op_a), .fp_op_b(fp_op_b),
    .fp_op_c(fp_op_c), .fp_pkt(fp_pkt)
  );

  function automatic logic [DW-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [1:0] acc, input logic [AW-1:0] a,
                                          input logic we, input logic wfp,
                                          input logic [AW-1:0] wa, input logic [DW-1:0] wd);
    if (acc == 2'b01) begin
      if (a == '0) return '0;
      if (we && !wfp && wa == a) return wd;
      return m_int[a];
    end
    if (acc == 2'b10) begin
      if (we && wfp && wa == a) return wd;
      return m_fp[a];
    end
    return '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] acc, input logic pf,
                      input logic [AW-1:0] a, input logic [AW-1:0] b, input logic [AW-1:0] c,
                      input logic [PKTW-1:0] pk, input logic we, input logic wfp,
                      input logic [AW-1:0] wa, input logic [DW-1:0] wd, input string tag);
    logic req, eix, efp;
    logic [DW-1:0] ea, eb, ec;
    in_valid = v; acc_code = acc; pipe_fp = pf;
    src_a = a; src_b = b; src_c = c; pkt_in = pk;
    wr_en = we; wr_fp = wfp; wr_addr = wa; wr_data = wd;
    req = v && (acc == 2'b01 || acc == 2'b10);
    eix = req && !pf;
    efp = req && pf;
    ea = exp_rd(acc, a, we, wfp, wa, wd);
    eb = exp_rd(acc, b, we, wfp, wa, wd);
    ec = exp_rd(acc, c, we, wfp, wa, wd);
    if (we) begin
      if (wfp) m_fp[wa] = wd;
      else if (wa != '0) m_int[wa] = wd;
    end
    @(negedge clk);
    chk({ix_valid, fp_valid} == {eix, efp}, {tag, " valids"},
        DW'({ix_valid, fp_valid}), DW'({eix, efp}));
    chk(ix_op_a == (eix ? ea : '0), {tag, " ix_a"}, ix_op_a, eix ? ea : '0);
    chk(ix_op_b == (eix ? eb : '0), {tag, " ix_b"}, ix_op_b, eix ? eb : '0);
    chk(ix_op_c == (eix ? ec : '0), {tag, " ix_c"}, ix_op_c, eix ? ec : '0);
    chk(ix_pkt == (eix ? pk : '0), {tag, " R6 ix_pkt"}, DW'(ix_pkt), DW'(eix ? pk : '0));
    chk(fp_op_a == (efp ? ea : '0), {tag, " fp_a"}, fp_op_a, efp ? ea : '0);
    chk(fp_op_b == (efp ? eb : '0), {tag, " fp_b"}, fp_op_b, efp ? eb : '0);
    chk(fp_op_c == (efp ? ec : '0), {tag, " fp_c"}, fp_op_c, efp ? ec : '0);
    chk(fp_pkt == (efp ? pk : '0), {tag, " R6 fp_pkt"}, DW'(fp_pkt), DW'(efp ? pk : '0));
  endtask

  initial begin
    #(150000 * 5.0);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NREG; i++) begin
      m_int[i] = '0;
      m_fp[i] = '0;
    end
    @(negedge clk);
    chk(!ix_valid && !fp_valid && ix_op_a == '0 && fp_op_a == '0 && ix_pkt == '0 && fp_pkt == '0,
        "R1 reset", DW'({ix_valid, fp_valid}), '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NREG; i++) begin
      step(1'b0, 2'b00, 1'b0, '0, '0, '0, '0, 1'b1, 1'b0, AW'(i), rnd64(), "R9 fill int");
      step(1'b0, 2'b00, 1'b0, '0, '0, '0, '0, 1'b1, 1'b1, AW'(i), rnd64(), "R9 fill fp");
    end

    step(1'b1, 2'b01, 1'b0, 5'd1, 5'd2, 5'd3, 16'h1111, 1'b0, 1'b0, '0, '0, "R3 R5 int to ix");
    step(1'b1, 2'b10, 1'b1, 5'd1, 5'd2, 5'd3, 16'h2222, 1'b0, 1'b0, '0, '0, "R3 R5 fp to fp");
    step(1'b1, 2'b01, 1'b1, 5'd4, 5'd5, 5'd6, 16'h3333, 1'b0, 1'b0, '0, '0, "R5 int to fp pipe");
    step(1'b1, 2'b10, 1'b0, 5'd4, 5'd5, 5'd6, 16'h4444, 1'b0, 1'b0, '0, '0, "R5 fp to ix pipe");
    step(1'b0, 2'b01, 1'b0, 5'd4, 5'd5, 5'd6, 16'h5555, 1'b0, 1'b0, '0, '0, "R2 idle after request");
    step(1'b1, 2'b00, 1'b0, 5'd7, 5'd8, 5'd9, 16'h6666, 1'b0, 1'b0, '0, '0, "R4 code 00");
    step(1'b1, 2'b11, 1'b1, 5'd7, 5'd8, 5'd9, 16'h7777, 1'b0, 1'b0, '0, '0, "R4 code 11");
    step(1'b0, 2'b00, 1'b0, '0, '0, '0, '0, 1'b1, 1'b0, 5'd0, 64'hDEAD_BEEF_0000_0001, "R7 write int r0");
    step(1'b1, 2'b01, 1'b0, 5'd0, 5'd0, 5'd0, 16'h0A0A, 1'b0, 1'b0, '0, '0, "R7 read int r0");
    step(1'b1, 2'b01, 1'b0, 5'd0, 5'd1, 5'd0, 16'h0B0B, 1'b1, 1'b0, 5'd0, 64'h1234_5678_9ABC_DEF0,
         "R7 same-cycle write r0");
    step(1'b0, 2'b00, 1'b0, '0, '0, '0, '0, 1'b1, 1'b1, 5'd0, 64'hCAFE_F00D_0000_0002, "R8 write fp r0");
    step(1'b1, 2'b10, 1'b1, 5'd0, 5'd0, 5'd31, 16'h0C0C, 1'b0, 1'b0, '0, '0, "R8 read fp r0");
    step(1'b1, 2'b01, 1'b0, 5'd5, 5'd6, 5'd5, 16'h0D0D, 1'b1, 1'b0, 5'd5, 64'hAAAA_0000_5555_FFFF,
         "R10 int bypass");
    step(1'b1, 2'b10, 1'b1, 5'd5, 5'd9, 5'd5, 16'h0E0E, 1'b1, 1'b0, 5'd5, 64'h0F0F_0F0F_0F0F_0F0F,
         "R10 R9 other-file write no bypass");
    step(1'b1, 2'b01, 1'b0, 5'd5, 5'd5, 5'd5, 16'h0F0F, 1'b0, 1'b0, '0, '0, "R9 int kept after fp-file read");
    step(1'b1, 2'b10, 1'b1, 5'd31, 5'd31, 5'd31, 16'h1F1F, 1'b1, 1'b1, 5'd31, 64'h8000_0000_0000_0001,
         "R11 R10 all ports r31 bypass");
    step(1'b1, 2'b01, 1'b0, 5'd31, 5'd30, 5'd1, 16'h2F2F, 1'b0, 1'b0, '0, '0, "R11 mixed addresses");
    step(1'b1, 2'b01, 1'b0, 5'd2, 5'd3, 5'd4, 16'h3F3F, 1'b0, 1'b0, '0, '0, "R2 back-to-back a");
    step(1'b1, 2'b10, 1'b1, 5'd2, 5'd3, 5'd4, 16'h4F4F, 1'b0, 1'b0, '0, '0, "R2 back-to-back b");

    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0, 3) != 0, 2'($urandom), 1'($urandom),
           AW'($urandom), AW'($urandom), AW'($urandom), PKTW'($urandom),
           $urandom_range(0, 1) == 1, 1'($urandom), AW'($urandom), rnd64(),
           "R2 R3 R4 R5 R10 R11 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule